// File: doc/BRIEF.md
# GPIO Pad Controller with Edge and Level Interrupts

A memory-mapped controller for a parameterised set of general-purpose pads. Every pad owns a configuration word through which software sets the pad's output value, reads back the pad's synchronised input level, chooses an optional input inversion, and picks how input activity turns into an interrupt event: level, rising edge, both edges, or none.

Events set sticky status bits packed 32 pads to a word. Software clears a bit by writing 1 to it. A matching enable word per group selects which status bits take part in one shared, registered interrupt line. Access goes through a single-cycle register port made of address, write data, write strobe and combinational read data.

Top module: `gpio_padctl`

## Requirements
- R1: The word for pad n sits at byte address 0x500 + 8*n. In that word, bit 0 is the output value and drives `pad_out[n]`, bit 23 is the inversion control, and bits 26:25 are the event mode. These bits read back as written, and all other bits except bit 1 read as zero.
- R2: Bit 1 of a pad word returns the pad input after a two-flop synchroniser, so the change shows after the second rising clock edge. Writes to bit 1 have no effect.
- R3: When bit 23 is 1, the input is inverted before event detection. The inverted value is called the effective input.
- R4: Mode 00 (level) sets the status bit in every cycle in which the effective input is 1, so the bit comes back at once after a clear while the input stays active.
- R5: Mode 01 (edge) sets the status bit only on a 0-to-1 change of the effective input. A falling change sets nothing, and a cleared bit stays clear while the input holds.
- R6: Mode 11 sets the status bit on any change of the effective input.
- R7: Mode 10 never sets a status bit.
- R8: Status word g is at 0x100 + 4*g and holds pads 32g..32g+31, with pad n at bit n%32. Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Enable word g is at 0x110 + 4*g with the same bit layout. Status and enable bits for pads at or above the pad count always read as zero.
- R10: `irq` is a register that goes high one clock edge after any status bit is set together with its enable bit, and falls one edge after no such pair remains.
- R11: After reset, all configuration, status, enable and output bits and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPADS | Raw pad input levels |
| pad_out | output | NPADS | Pad output values |
| addr | input | AW | Byte address of the register access |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench walks each event mode with and without inversion, on pads at both ends of a group. After each clear it checks that level mode re-sets the bit, while the edge modes leave it clear; a design that latched level events, or that detected edges before inversion, would give the wrong pair of results. It also looks for a falling input that wrongly sets status in rising-edge mode, and for mode 10 producing events. It checks that the readback of the last partial group masks the bits of pads that do not exist, and that a write of 0 does not wipe status. Finally it checks that `irq` follows the enable bit rather than the raw status.

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int NPADS = 78,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  input  logic             wen,
  output logic [31:0]      rdata,
  output logic             irq
);
  localparam int NG = (NPADS + 31) / 32;
  localparam int PW = NG * 32;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;
  localparam int IW = (NPADS > 1) ? $clog2(NPADS) : 1;
  localparam logic [AW-1:0] STS_BASE = AW'(12'h100);
  localparam logic [AW-1:0] EN_BASE  = AW'(12'h110);
  localparam logic [AW-1:0] CFG_BASE = AW'(12'h500);
  localparam logic [1:0] M_LEVEL = 2'b00, M_RISE = 2'b01, M_OFF = 2'b10, M_BOTH = 2'b11;

  logic [NPADS-1:0] drv, inv, sy1, sy2, eff, eff_d, ev, sts, en, clr_v, en_we, cfg_we;
  logic [1:0]       mode [NPADS];

  logic [AW-1:0] c_off, s_off, e_off;
  logic          cfg_hit, sts_hit, en_hit;
  logic [IW-1:0] pidx;
  logic [GW-1:0] sgrp, egrp;
  logic [PW-1:0] sts_w, en_w;

  assign c_off   = addr - CFG_BASE;
  assign s_off   = addr - STS_BASE;
  assign e_off   = addr - EN_BASE;
  assign cfg_hit = (addr >= CFG_BASE) && (c_off[2:0] == 3'b0) && (c_off[AW-1:3] < (AW-3)'(NPADS));
  assign sts_hit = (addr >= STS_BASE) && (s_off < AW'(4*NG)) && (s_off[1:0] == 2'b0);
  assign en_hit  = (addr >= EN_BASE)  && (e_off < AW'(4*NG)) && (e_off[1:0] == 2'b0);
  assign pidx    = IW'(c_off[AW-1:3]);
  assign sgrp    = s_off[GW+1:2];
  assign egrp    = e_off[GW+1:2];
  assign sts_w   = PW'(sts);
  assign en_w    = PW'(en);
  assign eff     = sy2 ^ inv;
  assign pad_out = drv;

  always_comb begin
    for (int i = 0; i < NPADS; i++) begin
      cfg_we[i] = wen && cfg_hit && (int'(pidx) == i);
      clr_v[i]  = wen && sts_hit && (int'(sgrp) == i / 32) && wdata[i % 32];
      en_we[i]  = wen && en_hit  && (int'(egrp) == i / 32);
      case (mode[i])
        M_LEVEL: ev[i] = eff[i];
        M_RISE:  ev[i] = eff[i] & ~eff_d[i];
        M_BOTH:  ev[i] = eff[i] ^ eff_d[i];
        default: ev[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1   <= '0;
      sy2   <= '0;
      eff_d <= '0;
      sts   <= '0;
      en    <= '0;
      drv   <= '0;
      inv   <= '0;
      irq   <= 1'b0;
      for (int i = 0; i < NPADS; i++) mode[i] <= M_LEVEL;
    end else begin
      sy1   <= pad_in;
      sy2   <= sy1;
      eff_d <= eff;
      sts   <= (sts & ~clr_v) | ev;
      irq   <= |(sts & en);
      for (int i = 0; i < NPADS; i++) begin
        if (en_we[i]) en[i] <= wdata[i % 32];
        if (cfg_we[i]) begin
          drv[i]  <= wdata[0];
          inv[i]  <= wdata[23];
          mode[i] <= wdata[26:25];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_hit) begin
      rdata[0]     = drv[pidx];
      rdata[1]     = sy2[pidx];
      rdata[23]    = inv[pidx];
      rdata[26:25] = mode[pidx];
    end else if (sts_hit) begin
      rdata = sts_w[{sgrp, 5'd0} +: 32];
    end else if (en_hit) begin
      rdata = en_w[{egrp, 5'd0} +: 32];
    end
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts) & ~$past(clr_v) & ~sts) == '0));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(clr_v & ~ev)) == '0));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(sts & en)));

  for (genvar g = 0; g < NPADS; g++) begin : g_chk
    assert_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] == M_OFF && !sts[g] && !cfg_we[g]) |=> !sts[g]);
  end
endmodule

// File: tb/gpio_padctl_bench.sv
module gpio_padctl_bench;
  localparam int NP = 78;
  logic clk = 1'b0, rst_n = 1'b0, wen = 1'b0, irq;
  logic [NP-1:0] pad_in = '0, pad_out;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_padctl #(.NPADS(NP), .AW(12)) u_gpio_padctl (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
    .addr(addr), .wdata(wdata), .wen(wen), .rdata(rdata), .irq(irq));

  // {pad[15:9], mode[8:7], inv[6], l0[5], l1[4], after_change[3], after_clear[2]}
  localparam logic [15:0] VEC [10] = '{
    {7'd5,  2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b0},
    {7'd31, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0},
    {7'd32, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0},
    {7'd77, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b0},
    {7'd0,  2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b0},
    {7'd63, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b0},
    {7'd64, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b0},
    {7'd12, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b0},
    {7'd45, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b0},
    {7'd70, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [11:0] cfa(input int p); return 12'(12'h500 + 8 * p); endfunction
  function automatic logic [11:0] sta(input int p); return 12'(12'h100 + 4 * (p / 32)); endfunction
  function automatic logic [11:0] ena(input int p); return 12'(12'h110 + 4 * (p / 32)); endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); @(negedge clk); rst_n = 1'b1;
    // R11 reset state
    rd(cfa(7), v);  chk("R11 cfg", v, 0);
    rd(sta(0), v);  chk("R11 sts", v, 0);
    rd(ena(40), v); chk("R11 en", v, 0);
    chk("R11 irq/out", {31'b0, irq} | 32'(pad_out != 0), 0);

    // R1 field layout and drive
    wr(cfa(3), 32'hFFFF_FFFF);
    rd(cfa(3), v); chk("R1 readback", v, 32'h0680_0001);
    chk("R1 pad_out", 32'(pad_out[3]), 1);
    wr(cfa(3), 0); cyc(3); wr(sta(3), 32'hFFFF_FFFF);

    // R2 synchroniser latency and read-only bit
    @(negedge clk); pad_in[40] = 1'b1;
    @(posedge clk); rd(cfa(40), v); chk("R2 one edge", v, 0);
    @(posedge clk); rd(cfa(40), v); chk("R2 two edges", v, 32'h2);
    wr(cfa(40), 0); rd(cfa(40), v); chk("R2 ro bit", v, 32'h2);
    @(negedge clk); pad_in[40] = 1'b0; cyc(4); wr(sta(40), 32'hFFFF_FFFF);

    // R3..R7 vector table
    for (int k = 0; k < 10; k++) begin
      automatic int p = int'(VEC[k][15:9]);
      automatic logic [31:0] m = 32'(1) << (p % 32);
      @(negedge clk); pad_in[p] = VEC[k][5];
      wr(cfa(p), {5'b0, VEC[k][8:7], 1'b0, VEC[k][6], 23'b0});
      cyc(6); wr(sta(p), m); cyc(2);
      @(negedge clk); pad_in[p] = VEC[k][4];
      cyc(6); rd(sta(p), v);
      chk($sformatf("R3-mode vec%0d change (R4 R5 R6 R7)", k), 32'((v & m) != 0), 32'(VEC[k][3]));
      wr(sta(p), m); cyc(3); rd(sta(p), v);
      chk($sformatf("R4/R5 vec%0d after clear", k), 32'((v & m) != 0), 32'(VEC[k][2]));
      wr(cfa(p), 0); @(negedge clk); pad_in[p] = 1'b0; cyc(4); wr(sta(p), m);
    end

    // R9 masking of nonexistent pads
    wr(ena(64), 32'hFFFF_FFFF); rd(ena(64), v); chk("R9 en mask", v, 32'h0000_3FFF);
    wr(ena(64), 0);
    wr(cfa(77), 32'h0080_0000); cyc(4); rd(sta(77), v); chk("R9 sts mask", v, 32'h0000_2000);
    wr(cfa(77), 0); cyc(2); wr(sta(77), 32'hFFFF_FFFF);

    // R8 write zero leaves status
    wr(cfa(70), 32'h0200_0000); cyc(2);
    @(negedge clk); pad_in[70] = 1'b1; cyc(5);
    wr(sta(70), 0); rd(sta(70), v); chk("R8 write zero", v, 32'h40);

    // R10 irq gated by enable
    cyc(2); chk("R10 irq masked", 32'(irq), 0);
    wr(ena(70), 32'h40); cyc(2); chk("R10 irq on", 32'(irq), 1);
    wr(sta(70), 32'h40); cyc(2); chk("R10 irq off", 32'(irq), 0);
    rd(sta(70), v); chk("R8 cleared", v, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule